// File: doc/BRIEF.md
# Execute Stage with Condition Codes

This block is the execute step of a sequential processor. Each cycle it receives a decoded instruction class (`icode`), a function selector (`ifun`), and three operand words: two register values and a constant. From these it produces the arithmetic result `val_e` within the same cycle. That result is a data value, an effective address or an adjusted stack pointer, depending on the instruction class.

The block holds a three-bit flag register (zero, sign, signed overflow). Only arithmetic/logic instructions write to it, and the write takes effect at the rising clock edge. A conditional jump uses no arithmetic. Instead it tests the stored flags against one of seven conditions and drives `take_br`. Because the flags change only at an edge, a jump always sees the outcome of an earlier instruction.

Instruction class codes on `icode` are: 0 halt, 1 nop, 2 register move, 3 immediate move, 4 store, 5 load, 6 arithmetic/logic, 7 jump, 8 call, 9 return, 10 push, 11 pop. Codes 12 to 15 are unused.

Top module: `ex_stage`

## Requirements
- R1: After reset the flags are zero = 1, sign = 0, overflow = 0. As a result, jumps with `ifun` 0, 1, 3 and 5 are taken, and jumps with `ifun` 2, 4 and 6 are not.
- R2: For `icode` 6, `val_e` is `val_b` OP `val_a` in the same cycle. The `ifun` value selects OP: 0 add, 1 subtract (`val_b` − `val_a`), 2 bitwise AND, 3 bitwise XOR. Any other `ifun` value adds.
- R3: For `icode` 4 and 5, `val_e` = `val_b` + `val_c`, modulo 2^32.
- R4: For `icode` 8 and 10, `val_e` = `val_b` − 4. For `icode` 9 and 11, `val_e` = `val_b` + 4. Both wrap modulo 2^32.
- R5: For `icode` 2, `val_e` = `val_a`. For `icode` 3, `val_e` = `val_c`. For `icode` 0, 1, 7 and 12 to 15, `val_e` = 0.
- R6: At a rising edge with `icode` 6, the flags load from the result: zero = (result == 0), sign = result bit 31, and overflow = signed overflow of the add or subtract. Overflow is 0 for AND and XOR.
- R7: At an edge with any `icode` other than 6, the flags keep their value.
- R8: With `icode` 7, `take_br` depends on `ifun` and the stored flags:
  - 0: always taken.
  - 1: (sign XOR overflow) OR zero.
  - 2: sign XOR overflow.
  - 3: zero.
  - 4: NOT zero.
  - 5: NOT (sign XOR overflow).
  - 6: NOT (sign XOR overflow) AND NOT zero.
  - 7 to 15: never taken.
- R9: `take_br` is 0 whenever `icode` is not 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| icode | input | 4 | Instruction class |
| ifun | input | 4 | Operation or condition selector |
| val_a | input | 32 | First register operand |
| val_b | input | 32 | Second register operand (stack pointer for stack operations) |
| val_c | input | 32 | Constant or displacement from the instruction |
| val_e | output | 32 | Execute result |
| take_br | output | 1 | Jump condition outcome |

## Verification
The flag register is the only state in the block, and it can be seen only through `take_br` on a later jump. A wrong flag value therefore shows up one cycle after the instruction that loaded it. That can happen too early or too late: a flag loaded by a non-arithmetic instruction, or a flag missed after an overflow. The bench probes every flag combination with all seven conditions at the next falling edge. It also repeats the probe after runs of other instructions, to expose loads that should not have happened. `val_e` is combinational, so operand-selection errors appear in the same cycle as the instruction.

// File: rtl/ex_pkg.sv
package ex_pkg;

  localparam logic [3:0] IC_HALT  = 4'd0;
  localparam logic [3:0] IC_NOP   = 4'd1;
  localparam logic [3:0] IC_RRMOV = 4'd2;
  localparam logic [3:0] IC_IRMOV = 4'd3;
  localparam logic [3:0] IC_STORE = 4'd4;
  localparam logic [3:0] IC_LOAD  = 4'd5;
  localparam logic [3:0] IC_ARITH = 4'd6;
  localparam logic [3:0] IC_JUMP  = 4'd7;
  localparam logic [3:0] IC_CALL  = 4'd8;
  localparam logic [3:0] IC_RET   = 4'd9;
  localparam logic [3:0] IC_PUSH  = 4'd10;
  localparam logic [3:0] IC_POP   = 4'd11;

  localparam logic [3:0] FN_ADD = 4'd0;
  localparam logic [3:0] FN_SUB = 4'd1;
  localparam logic [3:0] FN_AND = 4'd2;
  localparam logic [3:0] FN_XOR = 4'd3;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

  // Branch condition test on stored flags
  function automatic logic cond_eval(input logic [3:0] fn, input flags_t f);
    logic lt;
    lt = f.sf ^ f.of;
    case (fn)
      4'd0:    cond_eval = 1'b1;
      4'd1:    cond_eval = lt | f.zf;
      4'd2:    cond_eval = lt;
      4'd3:    cond_eval = f.zf;
      4'd4:    cond_eval = ~f.zf;
      4'd5:    cond_eval = ~lt;
      4'd6:    cond_eval = ~lt & ~f.zf;
      default: cond_eval = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ex_opnd_sel.sv
module ex_opnd_sel
  import ex_pkg::*;
#(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic [3:0]   icode,
  input  logic [3:0]   ifun,
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  input  logic [W-1:0] val_c,
  output logic [W-1:0] alu_a,
  output logic [W-1:0] alu_b,
  output logic [3:0]   alu_fn
);

  localparam logic [W-1:0] STEP_UP   = W'(STEP);
  localparam logic [W-1:0] STEP_DOWN = {W{1'b0}} - W'(STEP);

  always_comb begin
    case (icode)
      IC_RRMOV, IC_ARITH:           alu_a = val_a;
      IC_IRMOV, IC_STORE, IC_LOAD:  alu_a = val_c;
      IC_CALL, IC_PUSH:             alu_a = STEP_DOWN;
      IC_RET, IC_POP:               alu_a = STEP_UP;
      default:                      alu_a = '0;
    endcase
  end

  always_comb begin
    case (icode)
      IC_STORE, IC_LOAD, IC_ARITH,
      IC_CALL, IC_RET, IC_PUSH, IC_POP: alu_b = val_b;
      default:                          alu_b = '0;
    endcase
  end

  assign alu_fn = (icode == IC_ARITH) ? ifun : FN_ADD;

endmodule

// File: rtl/ex_alu.sv
module ex_alu
  import ex_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output flags_t       flags_next
);

  localparam int MSB = W - 1;

  function automatic logic [W-1:0] alu_result(input logic [3:0] f,
                                              input logic [W-1:0] x,
                                              input logic [W-1:0] y);
    case (f)
      FN_SUB:  alu_result = y - x;
      FN_AND:  alu_result = y & x;
      FN_XOR:  alu_result = y ^ x;
      default: alu_result = y + x;
    endcase
  endfunction

  function automatic logic alu_ovf(input logic [3:0] f,
                                   input logic [W-1:0] x,
                                   input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    case (f)
      FN_SUB:         alu_ovf = (x[MSB] != y[MSB]) && (r[MSB] != y[MSB]);
      FN_AND, FN_XOR: alu_ovf = 1'b0;
      default:        alu_ovf = (x[MSB] == y[MSB]) && (r[MSB] != y[MSB]);
    endcase
  endfunction

  always_comb begin
    res           = alu_result(fn, a, b);
    flags_next.zf = (res == '0);
    flags_next.sf = res[MSB];
    flags_next.of = alu_ovf(fn, a, b, res);
  end

endmodule

// File: rtl/ex_ccreg.sv
module ex_ccreg
  import ex_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= FLAGS_RESET;
    else if (load) q <= d;
  end

endmodule

// File: rtl/ex_branch.sv
module ex_branch
  import ex_pkg::*;
(
  input  logic [3:0] icode,
  input  logic [3:0] ifun,
  input  flags_t     flags,
  output logic       take
);

  assign take = (icode == IC_JUMP) && cond_eval(ifun, flags);

endmodule

// File: rtl/ex_stage.sv
module ex_stage
  import ex_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        icode,
  input  logic [3:0]        ifun,
  input  logic [DATA_W-1:0] val_a,
  input  logic [DATA_W-1:0] val_b,
  input  logic [DATA_W-1:0] val_c,
  output logic [DATA_W-1:0] val_e,
  output logic              take_br
);

  logic [DATA_W-1:0] alu_a;
  logic [DATA_W-1:0] alu_b;
  logic [3:0]        alu_fn;
  flags_t            cc_d;
  flags_t            cc_q;
  logic              set_cc;

  assign set_cc = (icode == IC_ARITH);

  ex_opnd_sel #(.W(DATA_W), .STEP(STEP)) u_sel (
    .icode (icode),
    .ifun  (ifun),
    .val_a (val_a),
    .val_b (val_b),
    .val_c (val_c),
    .alu_a (alu_a),
    .alu_b (alu_b),
    .alu_fn(alu_fn)
  );

  ex_alu #(.W(DATA_W)) u_alu (
    .fn        (alu_fn),
    .a         (alu_a),
    .b         (alu_b),
    .res       (val_e),
    .flags_next(cc_d)
  );

  ex_ccreg u_cc (
    .clk  (clk),
    .rst_n(rst_n),
    .load (set_cc),
    .d    (cc_d),
    .q    (cc_q)
  );

  ex_branch u_br (
    .icode(icode),
    .ifun (ifun),
    .flags(cc_q),
    .take (take_br)
  );

endmodule

module ex_stage_chk
  import ex_pkg::*;
#(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   icode,
  input logic [3:0]   ifun,
  input logic [W-1:0] val_b,
  input logic [W-1:0] val_e,
  input logic         take_br,
  input logic         set_cc,
  input flags_t       cc_d,
  input flags_t       cc_q
);

  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !set_cc |=> $stable(cc_q)); // R7

  AST_CC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    set_cc |=> (cc_q == $past(cc_d))); // R6

  AST_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (icode != IC_JUMP) |-> !take_br); // R9

  AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_JUMP && ifun == 4'd0) |-> take_br); // R8

  AST_JMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_JUMP && ifun == 4'd3) |-> (take_br == cc_q.zf)); // R8

  AST_STACK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_CALL || icode == IC_PUSH) |-> (val_e == val_b - W'(STEP))); // R4

endmodule

bind ex_stage ex_stage_chk #(.W(DATA_W), .STEP(STEP)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .icode  (icode),
  .ifun   (ifun),
  .val_b  (val_b),
  .val_e  (val_e),
  .take_br(take_br),
  .set_cc (set_cc),
  .cc_d   (cc_d),
  .cc_q   (cc_q)
);

// File: tb/ex_stage_bench.sv
module ex_stage_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  icode = 4'd1;
  logic [3:0]  ifun = 4'd0;
  logic [31:0] val_a = '0;
  logic [31:0] val_b = '0;
  logic [31:0] val_c = '0;
  logic [31:0] val_e;
  logic        take_br;

  int n_checks = 0;
  int n_fail   = 0;

  // bench-side model of the flags
  logic ez = 1'b1, es = 1'b0, eo = 1'b0;

  always #10 clk = ~clk;

  ex_stage u_ex_stage (
    .clk(clk), .rst_n(rst_n), .icode(icode), .ifun(ifun),
    .val_a(val_a), .val_b(val_b), .val_c(val_c),
    .val_e(val_e), .take_br(take_br)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // expected jump outcome, written from the condition table
  function automatic logic want_br(input int f);
    logic less;
    less = (es != eo);
    if (f == 0) return 1'b1;
    if (f == 1) return less || ez;
    if (f == 2) return less;
    if (f == 3) return ez;
    if (f == 4) return !ez;
    if (f == 5) return !less;
    if (f == 6) return !less && !ez;
    return 1'b0;
  endfunction

  task automatic probe_branches(input string req);
    for (int f = 0; f < 16; f++) begin
      icode = 4'd7; ifun = 4'(f);
      #1;
      chk(req, {31'd0, take_br}, {31'd0, want_br(f)});
    end
    icode = 4'd1; ifun = 4'd0;
    #1;
  endtask

  task automatic run_arith(input logic [3:0] fn, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    longint sa, sb, wide;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    case (fn)
      4'd1: begin r = b - a; wide = sb - sa; end
      4'd2: begin r = b & a; wide = longint'($signed(r)); end
      4'd3: begin r = b ^ a; wide = longint'($signed(r)); end
      default: begin r = b + a; wide = sb + sa; end
    endcase
    icode = 4'd6; ifun = fn; val_a = a; val_b = b;
    #1;
    chk("R2", val_e, r);
    @(posedge clk);
    ez = (r == 32'd0); es = r[31];
    eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
    @(negedge clk);
    icode = 4'd1;
    probe_branches("R6/R8");
  endtask

  task automatic t_reset;
    probe_branches("R1");
  endtask

  task automatic t_arith;
    run_arith(4'd0, 32'd3, 32'd5);
    run_arith(4'd1, 32'd5, 32'd3);
    run_arith(4'd1, 32'h1234, 32'h1234);
    run_arith(4'd0, 32'd1, 32'h7fffffff);
    run_arith(4'd1, 32'd1, 32'h80000000);
    run_arith(4'd2, 32'h0f0f, 32'hf0f0);
    run_arith(4'd3, 32'h8000ffff, 32'h0000ffff);
    run_arith(4'd9, 32'd10, 32'd20);
  endtask

  task automatic t_addr;
    icode = 4'd4; val_b = 32'h1000; val_c = 32'h24; #1;
    chk("R3", val_e, 32'h1024);
    icode = 4'd5; val_b = 32'hffff_fff0; val_c = 32'h20; #1;
    chk("R3", val_e, 32'h10);
  endtask

  task automatic t_stack;
    val_b = 32'h200;
    icode = 4'd8;  #1; chk("R4", val_e, 32'h1fc);
    icode = 4'd10; #1; chk("R4", val_e, 32'h1fc);
    icode = 4'd9;  #1; chk("R4", val_e, 32'h204);
    icode = 4'd11; #1; chk("R4", val_e, 32'h204);
    val_b = 32'h0; icode = 4'd8; #1; chk("R4", val_e, 32'hfffffffc);
  endtask

  task automatic t_moves;
    val_a = 32'hdead0001; val_b = 32'h55; val_c = 32'hbeef0002;
    icode = 4'd2; #1; chk("R5", val_e, 32'hdead0001);
    icode = 4'd3; #1; chk("R5", val_e, 32'hbeef0002);
    foreach (val_e[i]) if (i < 1) begin end
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c == 1 || c == 7 || c >= 12) begin
        icode = 4'(c); #1; chk("R5", val_e, 32'h0);
      end
    end
    icode = 4'd1; #1;
  endtask

  task automatic t_hold;
    // flags first set to a non-reset pattern: negative, no overflow
    run_arith(4'd1, 32'd9, 32'd2);
    for (int c = 0; c < 16; c++) begin
      if (c != 6) begin
        icode = 4'(c); ifun = 4'd1; val_a = '0; val_b = '0; val_c = '0;
        @(posedge clk); @(negedge clk);
      end
    end
    icode = 4'd1;
    probe_branches("R7");
  endtask

  task automatic t_nobr;
    for (int c = 0; c < 16; c++) begin
      if (c != 7) begin
        icode = 4'(c); ifun = 4'd0; #1;
        chk("R9", {31'd0, take_br}, 32'd0);
      end
    end
    icode = 4'd1; #1;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arith();
    t_addr();
    t_stack();
    t_moves();
    t_hold();
    t_nobr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule